// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs the bus side of a 16-bit processor whose address and data share one set of pins. A core-side request carries a 20-bit address, a read/write flag, a high-byte enable, a four-bit status nibble and, for writes, a data word. Each accepted request becomes a fixed four-state bus cycle, T1 to T4. In T1 the address goes out on the shared lines with a one-cycle latch strobe. From T2 onward the shared lines either float, so that memory can answer a read, or carry the write word. The upper four address lines switch over to status bits.

The command strobes follow the two halves of the clock. The read strobe and the data enable go low at the falling edge inside T2. The write strobe goes low as T2 begins and goes high again at the rising edge that starts T4. The word read back is captured at the end of T3 and returned to the core during T4, together with a one-cycle valid pulse. A parameter selects whether the "late in T2" moment uses the falling clock edge or is widened to the whole of T2.

Top module: `mbseq_bus_cycle`

## Requirements
- R1: After reset, and whenever no cycle is running, the outputs idle as follows: `ale`=0, `ad_oe`=0, `rd_n`=`wr_n`=`den_n`=`bhe_n`=1, `mem_io`=0, `dt_r`=0, `a_hi`=0, `busy`=0 and `rd_valid`=0.
- R2: A request with `req_valid`=1 is taken at a rising edge only when the sequencer is idle or in T4, and the next cycle is T1. `busy` is 1 through T1, T2 and T3. A request raised while `busy`=1 has no effect on the running cycle, and none is started from it.
- R3: In T1, `ale`=1 for exactly that one clock, `ad_oe`=1, `ad_out` equals address bits 15:0, and `a_hi` equals address bits 19:16.
- R4: In T2, T3 and T4, `a_hi` carries the request's status nibble in place of the address.
- R5: `mem_io`=1 and `dt_r` equals the write flag (1 write, 0 read) through all of T1 to T4. `bhe_n` is the inverse of the high-byte enable and is held through T1 to T4.
- R6: On a read, `ad_oe`=0 from T2 through T4. `rd_n` and `den_n` are 0 from the falling edge inside T2 to the end of T3, and 1 at all other times.
- R7: On a read, `ad_in` is sampled at the rising edge that ends T3. During T4 `rd_data` holds that word and `rd_valid`=1 for that one cycle only.
- R8: On a write, `wr_n`=0 through T2 and T3 and returns to 1 as T4 starts. `den_n`=0 through T2 to T4. `ad_oe`=1 and `ad_out` holds the write word from the falling edge inside T2 through the end of T4. In the first half of T2, `ad_oe`=0.
- R9: A request present during T4 starts its T1 on the very next clock, with no idle cycle in between.
- R10: `rd_n` and `wr_n` are never 0 together. `ad_oe` is never 1 while `rd_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; states change on rising edges |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | 20 | Byte address |
| req_hi_en | input | 1 | Access the high byte lane |
| req_stat | input | 4 | Status nibble for the upper lines in T2 to T4 |
| req_wdata | input | 16 | Write word |
| busy | output | 1 | Cycle in T1 to T3; requests are ignored |
| rd_valid | output | 1 | Read word valid (T4 of a read) |
| rd_data | output | 16 | Word captured at the end of T3 |
| ad_out | output | 16 | Shared address/data lines, driven value |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_in | input | 16 | Shared address/data lines, received value |
| a_hi | output | 4 | Upper address lines / status |
| ale | output | 1 | Address latch strobe |
| mem_io | output | 1 | 1 during a memory cycle |
| dt_r | output | 1 | Transceiver direction, 1 = transmit |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Data path enable, active low |
| bhe_n | output | 1 | High byte enable, active low |

## Verification
The assertions assume that the core's request lines are stable around each rising edge and that `ad_in` is set up before the edge that ends T3. The bench changes every input one time unit after a rising edge or two units after a falling edge, and it loads the read word into `ad_in` only during T3. The bench observes every output in both halves of every state, for reads and writes, for all byte-lane choices, for several addresses and status values, for back-to-back cycles and for a request raised while the sequencer is busy.

// File: rtl/mbseq_pkg.sv
package mbseq_pkg;
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_T1   = 3'd1,
      PH_T2   = 3'd2,
      PH_T3   = 3'd3,
      PH_T4   = 3'd4
   } phase_e;
endpackage

// File: rtl/mbseq_ctrl.sv
module mbseq_ctrl
   import mbseq_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16,
   localparam int STAT_W = ADDR_W - DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_hi_en,
   input  logic [STAT_W-1:0] req_stat,
   input  logic [DATA_W-1:0] req_wdata,
   output phase_e            phase,
   output logic              cur_write,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              cur_hi_en,
   output logic [STAT_W-1:0] cur_stat,
   output logic [DATA_W-1:0] cur_wdata,
   output logic              busy
);
   logic   take;
   phase_e phase_nx;

   assign take = req_valid && (phase == PH_IDLE || phase == PH_T4);
   assign busy = (phase == PH_T1) || (phase == PH_T2) || (phase == PH_T3);

   always_comb begin
      unique case (phase)
         PH_T1:   phase_nx = PH_T2;
         PH_T2:   phase_nx = PH_T3;
         PH_T3:   phase_nx = PH_T4;
         default: phase_nx = take ? PH_T1 : PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         cur_write <= 1'b0;
         cur_addr  <= '0;
         cur_hi_en <= 1'b0;
         cur_stat  <= '0;
         cur_wdata <= '0;
      end else begin
         phase <= phase_nx;
         if (take) begin
            cur_write <= req_write;
            cur_addr  <= req_addr;
            cur_hi_en <= req_hi_en;
            cur_stat  <= req_stat;
            cur_wdata <= req_wdata;
         end
      end
   end
endmodule

// File: rtl/mbseq_half.sv
module mbseq_half
   import mbseq_pkg::*;
#(
   parameter bit LATE_ON_FALL = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  phase_e phase,
   output logic   late_t2
);
   generate
      if (LATE_ON_FALL) begin : g_fall
         logic fell_in_t2;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) fell_in_t2 <= 1'b0;
            else        fell_in_t2 <= (phase == PH_T2);
         end
         assign late_t2 = fell_in_t2 && (phase == PH_T2);
      end else begin : g_whole
         logic unused_ok;
         assign unused_ok = clk ^ rst_n;
         assign late_t2   = (phase == PH_T2);
      end
   endgenerate
endmodule

// File: rtl/mbseq_pins.sv
module mbseq_pins
   import mbseq_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16,
   localparam int STAT_W = ADDR_W - DATA_W
) (
   input  phase_e            phase,
   input  logic              late_t2,
   input  logic              cur_write,
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic              cur_hi_en,
   input  logic [STAT_W-1:0] cur_stat,
   input  logic [DATA_W-1:0] cur_wdata,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic [STAT_W-1:0] a_hi,
   output logic              ale,
   output logic              mem_io,
   output logic              dt_r,
   output logic              rd_n,
   output logic              wr_n,
   output logic              den_n,
   output logic              bhe_n
);
   logic in_t1, in_t3, in_t4, active, rd_win, wr_data_win;

   assign in_t1  = (phase == PH_T1);
   assign in_t3  = (phase == PH_T3);
   assign in_t4  = (phase == PH_T4);
   assign active = (phase != PH_IDLE);

   assign rd_win      = late_t2 || in_t3;
   assign wr_data_win = late_t2 || in_t3 || in_t4;

   assign ale    = in_t1;
   assign mem_io = active;
   assign dt_r   = active && cur_write;
   assign bhe_n  = !(active && cur_hi_en);
   assign a_hi   = in_t1 ? cur_addr[ADDR_W-1:DATA_W] : (active ? cur_stat : '0);

   assign ad_oe  = in_t1 || (cur_write && wr_data_win);
   assign ad_out = in_t1 ? cur_addr[DATA_W-1:0] : (ad_oe ? cur_wdata : '0);

   assign rd_n   = !(!cur_write && rd_win);
   assign wr_n   = !(cur_write && (phase == PH_T2 || in_t3));
   assign den_n  = !(cur_write ? (phase == PH_T2 || in_t3 || in_t4) : rd_win);
endmodule

// File: rtl/mbseq_rdcap.sv
module mbseq_rdcap
   import mbseq_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  phase_e            phase,
   input  logic              cur_write,
   input  logic [DATA_W-1:0] ad_in,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= (phase == PH_T3) && !cur_write;
         if (phase == PH_T3 && !cur_write) rd_data <= ad_in;
      end
   end
endmodule

// File: rtl/mbseq_bus_cycle.sv
module mbseq_bus_cycle
   import mbseq_pkg::*;
#(
   parameter int ADDR_W       = 20,
   parameter int DATA_W       = 16,
   parameter bit LATE_ON_FALL = 1'b1,
   localparam int STAT_W      = ADDR_W - DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_hi_en,
   input  logic [STAT_W-1:0] req_stat,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   input  logic [DATA_W-1:0] ad_in,
   output logic [STAT_W-1:0] a_hi,
   output logic              ale,
   output logic              mem_io,
   output logic              dt_r,
   output logic              rd_n,
   output logic              wr_n,
   output logic              den_n,
   output logic              bhe_n
);
   generate
      if (ADDR_W <= DATA_W) begin : g_bad_width
         $error("mbseq_bus_cycle: ADDR_W must exceed DATA_W");
      end
      if (DATA_W < 8 || DATA_W % 8 != 0) begin : g_bad_data
         $error("mbseq_bus_cycle: DATA_W must be a multiple of 8");
      end
   endgenerate

   phase_e            phase;
   logic              late_t2;
   logic              cur_write, cur_hi_en;
   logic [ADDR_W-1:0] cur_addr;
   logic [STAT_W-1:0] cur_stat;
   logic [DATA_W-1:0] cur_wdata;

   mbseq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_hi_en(req_hi_en), .req_stat(req_stat),
      .req_wdata(req_wdata), .phase(phase), .cur_write(cur_write),
      .cur_addr(cur_addr), .cur_hi_en(cur_hi_en), .cur_stat(cur_stat),
      .cur_wdata(cur_wdata), .busy(busy)
   );

   mbseq_half #(.LATE_ON_FALL(LATE_ON_FALL)) u_half (
      .clk(clk), .rst_n(rst_n), .phase(phase), .late_t2(late_t2)
   );

   mbseq_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
      .phase(phase), .late_t2(late_t2), .cur_write(cur_write),
      .cur_addr(cur_addr), .cur_hi_en(cur_hi_en), .cur_stat(cur_stat),
      .cur_wdata(cur_wdata), .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi),
      .ale(ale), .mem_io(mem_io), .dt_r(dt_r), .rd_n(rd_n), .wr_n(wr_n),
      .den_n(den_n), .bhe_n(bhe_n)
   );

   mbseq_rdcap #(.DATA_W(DATA_W)) u_rdcap (
      .clk(clk), .rst_n(rst_n), .phase(phase), .cur_write(cur_write),
      .ad_in(ad_in), .rd_valid(rd_valid), .rd_data(rd_data)
   );
endmodule

// File: rtl/mbseq_bus_cycle_chk.sv
module mbseq_bus_cycle_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic ale,
   input logic ad_oe,
   input logic rd_n,
   input logic wr_n,
   input logic den_n,
   input logic dt_r,
   input logic rd_valid
);
   assert_ale_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !ale);

   assert_ale_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> busy);

   assert_no_dual_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));

   assert_no_drive_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(ad_oe && !rd_n));

   assert_rdvalid_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(!rd_n && !den_n));

   assert_dir_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(dt_r));

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !rd_valid && !dt_r && !ale) |-> (rd_n && wr_n));
endmodule

bind mbseq_bus_cycle mbseq_bus_cycle_chk u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .ale(ale), .ad_oe(ad_oe),
   .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .dt_r(dt_r), .rd_valid(rd_valid)
);

// File: tb/mbseq_bus_cycle_tb.sv
module mbseq_bus_cycle_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_hi_en = 1'b0;
   logic [19:0] req_addr = '0;
   logic [3:0]  req_stat = '0;
   logic [15:0] req_wdata = '0, ad_in = 16'hDEAD;
   logic        busy, rd_valid, ad_oe, ale, mem_io, dt_r, rd_n, wr_n, den_n, bhe_n;
   logic [15:0] rd_data, ad_out;
   logic [3:0]  a_hi;
   int checks = 0, fails = 0;
   bit done = 0;

   always #4 clk = ~clk;

   mbseq_bus_cycle u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_hi_en(req_hi_en), .req_stat(req_stat),
      .req_wdata(req_wdata), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
      .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi), .ale(ale),
      .mem_io(mem_io), .dt_r(dt_r), .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n),
      .bhe_n(bhe_n)
   );

   function automatic logic [15:0] memval(input logic [19:0] a);
      return a[15:0] ^ 16'h5A3C ^ {a[19:16], 12'h0};
   endfunction

   task automatic chk(input string req, input string nm, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, nm, act, exp);
      end
   endtask

   task automatic chk_idle(input string tag);
      chk("R1", {tag, " ale"}, ale, 0);
      chk("R1", {tag, " ad_oe"}, ad_oe, 0);
      chk("R1", {tag, " strobes"}, {rd_n, wr_n, den_n, bhe_n}, 4'hF);
      chk("R1", {tag, " mem_io/dt_r"}, {mem_io, dt_r}, 0);
      chk("R1", {tag, " a_hi"}, a_hi, 0);
      chk("R2", {tag, " busy"}, busy, 0);
      chk("R7", {tag, " rd_valid"}, rd_valid, 0);
   endtask

   task automatic set_req(input logic w, input logic [19:0] a, input logic hi,
                          input logic [3:0] st, input logic [15:0] wd);
      req_valid = 1'b1; req_write = w; req_addr = a;
      req_hi_en = hi; req_stat = st; req_wdata = wd;
   endtask

   task automatic expect_state(input int k, input int h, input logic w,
                               input logic [19:0] a, input logic hi,
                               input logic [3:0] st, input logic [15:0] wd);
      logic late, e_oe, e_rd, e_wr, e_den;
      late  = (k == 1 && h == 1);
      e_oe  = (k == 0) || (w && (late || k >= 2));
      e_rd  = !w && (late || k == 2);
      e_wr  = w && (k == 1 || k == 2);
      e_den = w ? (k >= 1) : (late || k == 2);
      chk("R3", "ale", ale, k == 0);
      chk(w ? "R8" : "R6", "ad_oe", ad_oe, e_oe);
      if (k == 0) chk("R3", "ad_out addr", ad_out, a[15:0]);
      else if (e_oe) chk("R8", "ad_out wdata", ad_out, wd);
      chk(k == 0 ? "R3" : "R4", "a_hi", a_hi, k == 0 ? a[19:16] : st);
      chk("R5", "mem_io", mem_io, 1);
      chk("R5", "dt_r", dt_r, w);
      chk("R5", "bhe_n", bhe_n, !hi);
      chk("R6", "rd_n", rd_n, !e_rd);
      chk("R8", "wr_n", wr_n, !e_wr);
      chk(w ? "R8" : "R6", "den_n", den_n, !e_den);
      chk("R10", "rd/wr exclusive", {rd_n | wr_n}, 1);
      chk("R2", "busy", busy, k < 3);
      chk("R7", "rd_valid", rd_valid, (k == 3) && !w);
      if (k == 3 && !w) chk("R7", "rd_data", rd_data, memval(a));
   endtask

   // Request must already be presented; call before the accepting edge.
   task automatic track(input logic w, input logic [19:0] a, input logic hi,
                        input logic [3:0] st, input logic [15:0] wd,
                        input bit ghost);
      for (int k = 0; k < 4; k++) begin
         @(posedge clk); #1;
         if (k == 0) req_valid = 1'b0;
         if (k == 1 && ghost) set_req(!w, a ^ 20'h8_4321, !hi, ~st, ~wd);
         if (k == 2) begin
            req_valid = 1'b0;
            ad_in = memval(a);
         end
         if (k == 3) ad_in = 16'hDEAD;
         #1;
         expect_state(k, 0, w, a, hi, st, wd);
         @(negedge clk); #2;
         expect_state(k, 1, w, a, hi, st, wd);
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL R2 watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [19:0] addrs [4];
      addrs[0] = 20'h0_0000; addrs[1] = 20'hF_FFFF;
      addrs[2] = 20'hA_1235; addrs[3] = 20'h5_CDE2;
      #6;
      chk_idle("reset");
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk); #2 chk_idle("after reset");

      // R3 R4 R5 R6 R7 R8: sweep direction, byte lane, address, status
      for (int w = 0; w < 2; w++)
         for (int hi = 0; hi < 2; hi++)
            for (int ai = 0; ai < 4; ai++) begin
               logic [15:0] wd;
               logic [3:0]  st;
               wd = 16'h1111 * 16'(ai + 1) ^ 16'(w * 16'h8001);
               st = 4'(ai * 5 + hi * 3 + w);
               @(posedge clk); #1;
               set_req(w[0], addrs[ai], hi[0], st, wd);
               track(w[0], addrs[ai], hi[0], st, wd, 1'b0);
               @(posedge clk); #2 chk_idle("gap");
            end

      // R9: back-to-back read then write then read
      @(posedge clk); #1;
      set_req(1'b0, 20'h3_0F0E, 1'b1, 4'h6, 16'h0);
      track(1'b0, 20'h3_0F0E, 1'b1, 4'h6, 16'h0, 1'b0);
      set_req(1'b1, 20'h7_7777, 1'b0, 4'h9, 16'hBEEF);
      track(1'b1, 20'h7_7777, 1'b0, 4'h9, 16'hBEEF, 1'b0);
      set_req(1'b0, 20'h1_0001, 1'b0, 4'hC, 16'h0);
      track(1'b0, 20'h1_0001, 1'b0, 4'hC, 16'h0, 1'b0);
      @(posedge clk); #2 chk_idle("R9 end");

      // R2: request raised during busy is ignored
      @(posedge clk); #1;
      set_req(1'b1, 20'h2_4680, 1'b1, 4'h3, 16'hC0DE);
      track(1'b1, 20'h2_4680, 1'b1, 4'h3, 16'hC0DE, 1'b1);
      @(posedge clk); #2 chk_idle("R2 ghost ignored");
      @(posedge clk); #2 chk_idle("R2 ghost still idle");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule